// File: doc/BRIEF.md
# Interleaved Four-Bank SRAM Arbiter

This block puts one on-chip SRAM behind three masters: a 64-bit processor port and two 32-bit DMA ports. The storage is split into four 32-bit banks, and consecutive word addresses fall in consecutive banks. Each bank runs its own arbitration every cycle. Two masters that work in different banks therefore proceed in the same cycle. A DMA burst can enter a bank as soon as a higher-priority burst has moved on to the next bank, without waiting for that burst to finish.

Each port moves one beat per cycle with a valid/ready handshake. The master walks its own burst by advancing the address after every accepted beat. A processor beat covers two neighbouring banks in one cycle. The processor always wins its banks, so its timing matches a single wide memory. Between the two DMA ports the priority is either fixed (DMA0 first) or round-robin, chosen by one mode input. A read returns its data one cycle after the grant, routed to the port that won the bank.

Top module: `banked_sram_arb`

## Requirements
- R1: A DMA word address `a` maps to bank `a[1:0]` and row `a[ADDR_W-1:2]`. A word written through any port reads back unchanged through any other port at the same word address.
- R2: The processor address counts 64-bit pairs. Pair `p` covers word `2p` (bank `{p[0],0}`) on data bits [31:0] and word `2p+1` (bank `{p[0],1}`) on bits [63:32]. Both words are accessed in the same cycle.
- R3: `cpu_ready` equals `cpu_valid` in every cycle and in both priority modes, so the processor never waits.
- R4: A DMA beat is granted in the cycle it is offered when neither the processor nor a higher-priority DMA targets its bank. With the processor reading words 0–3 and both DMAs reading words 0–3 from the same cycle, DMA0 is granted one cycle after the processor's first beat and DMA1 two cycles after it.
- R5: With `rr_mode`=0, DMA0 wins over DMA1 in a shared bank. DMA1 holds its beat until the bank is free.
- R6: With `rr_mode`=1, each bank keeps its own pointer, which favours DMA0 after reset. When the bank grants a DMA beat, the pointer moves to favour the other DMA, and it changes at no other time. DMAs contending in one bank therefore alternate.
- R7: A granted read raises the port's `rvalid` for exactly the next cycle, with the data. Writes and idle cycles produce no `rvalid`.
- R8: During and right after reset all `rvalid` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 1 = round-robin between DMAs, 0 = fixed priority |
| cpu_valid | input | 1 | Processor beat offered |
| cpu_ready | output | 1 | Processor beat accepted this cycle |
| cpu_addr | input | ADDR_W-1 | Processor 64-bit pair address |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_wdata | input | 64 | Processor write data |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | 64 | Processor read data |
| d0_valid | input | 1 | DMA0 beat offered |
| d0_ready | output | 1 | DMA0 beat accepted |
| d0_addr | input | ADDR_W | DMA0 word address |
| d0_we | input | 1 | DMA0 write (1) or read (0) |
| d0_wdata | input | 32 | DMA0 write data |
| d0_rvalid | output | 1 | DMA0 read data valid |
| d0_rdata | output | 32 | DMA0 read data |
| d1_valid | input | 1 | DMA1 beat offered |
| d1_ready | output | 1 | DMA1 beat accepted |
| d1_addr | input | ADDR_W | DMA1 word address |
| d1_we | input | 1 | DMA1 write (1) or read (0) |
| d1_wdata | input | 32 | DMA1 write data |
| d1_rvalid | output | 1 | DMA1 read data valid |
| d1_rdata | output | 32 | DMA1 read data |

## Verification
The properties assume that a master keeps its valid, address and write flag steady while its beat is stalled. They also assume that `rr_mode` only changes across a reset. Otherwise the alternation check, which compares two consecutive contended cycles, would mix the two modes. The bench drives every beat from tasks that hold all fields until ready is seen, and it changes the mode only while reset is asserted. It never raises a valid during reset.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA0 = 2'd2,
        OWN_DMA1 = 2'd3
    } owner_e;

    typedef struct packed {
        logic fav_d1;
    } arb_state_t;

    typedef struct packed {
        owner_e [NBANK-1:0] rtag;
    } ret_state_t;
endpackage

// File: rtl/bank_arbiter.sv
module bank_arbiter
    import sram_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rr_mode,
    input  logic   cpu_req,
    input  logic   d0_req,
    input  logic   d1_req,
    output owner_e win
);
    arb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        win = OWN_NONE;
        if (cpu_req) begin
            win = OWN_CPU;
        end else if (d0_req && d1_req) begin
            win = (rr_mode && s_q.fav_d1) ? OWN_DMA1 : OWN_DMA0;
        end else if (d0_req) begin
            win = OWN_DMA0;
        end else if (d1_req) begin
            win = OWN_DMA1;
        end
        if (rr_mode && (win == OWN_DMA0 || win == OWN_DMA1)) begin
            s_d.fav_d1 = (win == OWN_DMA0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int ROWS  = 16,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    logic [31:0] mem_q [ROWS];
    logic [31:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem_q[row] <= wdata;
            else    rdata_q    <= mem_q[row];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/banked_sram_arb.sv
module banked_sram_arb
    import sram_arb_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = ROW_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rr_mode,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [ADDR_W-2:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [63:0]       cpu_wdata,
    output logic              cpu_rvalid,
    output logic [63:0]       cpu_rdata,
    input  logic              d0_valid,
    output logic              d0_ready,
    input  logic [ADDR_W-1:0] d0_addr,
    input  logic              d0_we,
    input  logic [31:0]       d0_wdata,
    output logic              d0_rvalid,
    output logic [31:0]       d0_rdata,
    input  logic              d1_valid,
    output logic              d1_ready,
    input  logic [ADDR_W-1:0] d1_addr,
    input  logic              d1_we,
    input  logic [31:0]       d1_wdata,
    output logic              d1_rvalid,
    output logic [31:0]       d1_rdata
);
    owner_e           win      [NBANK];
    logic             bank_en  [NBANK];
    logic             bank_we  [NBANK];
    logic [ROW_W-1:0] bank_row [NBANK];
    logic [31:0]      bank_wd  [NBANK];
    logic [31:0]      bank_rd  [NBANK];

    ret_state_t st_d, st_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [BANK_W-1:0] BI = BANK_W'(b);
        logic cpu_hit, d0_hit, d1_hit;

        assign cpu_hit = cpu_valid && (cpu_addr[0] == BI[1]);
        assign d0_hit  = d0_valid && (d0_addr[BANK_W-1:0] == BI);
        assign d1_hit  = d1_valid && (d1_addr[BANK_W-1:0] == BI);

        bank_arbiter i_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .rr_mode (rr_mode),
            .cpu_req (cpu_hit),
            .d0_req  (d0_hit),
            .d1_req  (d1_hit),
            .win     (win[b])
        );

        assign bank_en[b]  = (win[b] != OWN_NONE);
        assign bank_we[b]  = (win[b] == OWN_CPU)  ? cpu_we :
                             (win[b] == OWN_DMA0) ? d0_we  :
                             (win[b] == OWN_DMA1) ? d1_we  : 1'b0;
        assign bank_row[b] = (win[b] == OWN_CPU)  ? cpu_addr[ADDR_W-2:1] :
                             (win[b] == OWN_DMA1) ? d1_addr[ADDR_W-1:BANK_W] :
                                                    d0_addr[ADDR_W-1:BANK_W];
        assign bank_wd[b]  = (win[b] == OWN_CPU)  ? (BI[0] ? cpu_wdata[63:32] : cpu_wdata[31:0]) :
                             (win[b] == OWN_DMA1) ? d1_wdata : d0_wdata;

        sram_bank #(.ROWS(ROWS)) i_mem (
            .clk   (clk),
            .en    (bank_en[b]),
            .we    (bank_we[b]),
            .row   (bank_row[b]),
            .wdata (bank_wd[b]),
            .rdata (bank_rd[b])
        );
    end

    assign cpu_ready = cpu_valid
                    && (win[{cpu_addr[0], 1'b0}] == OWN_CPU)
                    && (win[{cpu_addr[0], 1'b1}] == OWN_CPU);
    assign d0_ready  = (win[d0_addr[BANK_W-1:0]] == OWN_DMA0);
    assign d1_ready  = (win[d1_addr[BANK_W-1:0]] == OWN_DMA1);

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBANK; b++) begin
            st_d.rtag[b] = (bank_en[b] && !bank_we[b]) ? win[b] : OWN_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cpu_rvalid = (st_q.rtag[0] == OWN_CPU) || (st_q.rtag[2] == OWN_CPU);
        cpu_rdata  = (st_q.rtag[0] == OWN_CPU) ? {bank_rd[1], bank_rd[0]}
                                               : {bank_rd[3], bank_rd[2]};
        d0_rvalid  = 1'b0;
        d0_rdata   = '0;
        d1_rvalid  = 1'b0;
        d1_rdata   = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (st_q.rtag[b] == OWN_DMA0) begin
                d0_rvalid = 1'b1;
                d0_rdata  = bank_rd[b];
            end
            if (st_q.rtag[b] == OWN_DMA1) begin
                d1_rvalid = 1'b1;
                d1_rdata  = bank_rd[b];
            end
        end
    end
endmodule

// File: rtl/banked_sram_arb_chk.sv
module banked_sram_arb_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rr_mode,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic [ADDR_W-2:0] cpu_addr,
    input logic              cpu_we,
    input logic              cpu_rvalid,
    input logic              d0_valid,
    input logic              d0_ready,
    input logic [ADDR_W-1:0] d0_addr,
    input logic              d0_we,
    input logic              d0_rvalid,
    input logic              d1_valid,
    input logic              d1_ready,
    input logic [ADDR_W-1:0] d1_addr,
    input logic              d1_we,
    input logic              d1_rvalid
);
    logic same_bank, cpu_on_d0, cpu_on_d1, contend;
    assign same_bank = (d0_addr[1:0] == d1_addr[1:0]);
    assign cpu_on_d0 = cpu_valid && (cpu_addr[0] == d0_addr[1]);
    assign cpu_on_d1 = cpu_valid && (cpu_addr[0] == d1_addr[1]);
    assign contend   = d0_valid && d1_valid && same_bank && !cpu_on_d0;

    // R3
    a_r3_cpu_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> cpu_ready);

    // R4
    a_r4_one_owner_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_ready && d1_ready) |-> !same_bank);
    a_r4_cpu_excludes_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && (d0_ready || d1_ready)) |-> !((d0_ready && cpu_on_d0) || (d1_ready && cpu_on_d1)));
    a_r4_free_bank_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_valid && !cpu_on_d0 && !(d1_valid && same_bank)) |-> d0_ready);

    // R5
    a_r5_fixed_d0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_mode && d0_valid && d1_valid && same_bank) |-> !d1_ready);

    // R6
    a_r6_rr_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_mode && contend && $past(rst_n) && $past(rr_mode) && $past(contend)
         && $past(d0_ready) && ($past(d0_addr[1:0]) == d0_addr[1:0])) |-> d1_ready);

    // R7
    a_r7_cpu_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_we) |=> cpu_rvalid);
    a_r7_cpu_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && !cpu_we) |=> !cpu_rvalid);
    a_r7_d0_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_ready && !d0_we) |=> d0_rvalid);
    a_r7_d0_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(d0_ready && !d0_we) |=> !d0_rvalid);
    a_r7_d1_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        (d1_ready && !d1_we) |=> d1_rvalid);
    a_r7_d1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(d1_ready && !d1_we) |=> !d1_rvalid);

    // R8
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(cpu_rvalid || d0_rvalid || d1_rvalid));
endmodule

bind banked_sram_arb banked_sram_arb_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rr_mode    (rr_mode),
    .cpu_valid  (cpu_valid),
    .cpu_ready  (cpu_ready),
    .cpu_addr   (cpu_addr),
    .cpu_we     (cpu_we),
    .cpu_rvalid (cpu_rvalid),
    .d0_valid   (d0_valid),
    .d0_ready   (d0_ready),
    .d0_addr    (d0_addr),
    .d0_we      (d0_we),
    .d0_rvalid  (d0_rvalid),
    .d1_valid   (d1_valid),
    .d1_ready   (d1_ready),
    .d1_addr    (d1_addr),
    .d1_we      (d1_we),
    .d1_rvalid  (d1_rvalid)
);

// File: tb/test_banked_sram_arb.sv
`timescale 1ns/1ps
module test_banked_sram_arb;
    localparam int ROWS   = 16;
    localparam int AW     = 6;
    localparam int NWORDS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rr_mode = 1'b0;
    logic cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [AW-2:0] cpu_addr = '0;
    logic [63:0] cpu_wdata = '0;
    logic cpu_ready, cpu_rvalid;
    logic [63:0] cpu_rdata;
    logic d0_valid = 1'b0, d0_we = 1'b0, d1_valid = 1'b0, d1_we = 1'b0;
    logic [AW-1:0] d0_addr = '0, d1_addr = '0;
    logic [31:0] d0_wdata = '0, d1_wdata = '0;
    logic d0_ready, d0_rvalid, d1_ready, d1_rvalid;
    logic [31:0] d0_rdata, d1_rdata;

    always #2 clk = ~clk;

    banked_sram_arb #(.ROWS(ROWS)) i_banked_sram_arb (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .d0_valid(d0_valid), .d0_ready(d0_ready), .d0_addr(d0_addr),
        .d0_we(d0_we), .d0_wdata(d0_wdata), .d0_rvalid(d0_rvalid), .d0_rdata(d0_rdata),
        .d1_valid(d1_valid), .d1_ready(d1_ready), .d1_addr(d1_addr),
        .d1_we(d1_we), .d1_wdata(d1_wdata), .d1_rvalid(d1_rvalid), .d1_rdata(d1_rdata)
    );

    typedef struct {
        logic [63:0] data;
        int          due;
    } exp_t;

    exp_t q_c[$], q_0[$], q_1[$];
    exp_t e_c, e_0, e_1;
    logic [31:0] model [NWORDS];
    int g0 [8], g1 [8], gc [8];
    int cyc = 0;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // scoreboard monitors
    always @(negedge clk) begin
        if (rst_n && cpu_rvalid) begin
            if (q_c.size() == 0) chk(1'b0, "R7 cpu rvalid without read", 64'd1, 64'd0);
            else begin
                e_c = q_c.pop_front();
                chk(cpu_rdata == e_c.data, "R2 cpu read data", cpu_rdata, e_c.data);
                chk(cyc == e_c.due, "R7 cpu return cycle", 64'(cyc), 64'(e_c.due));
            end
        end
        if (rst_n && d0_rvalid) begin
            if (q_0.size() == 0) chk(1'b0, "R7 d0 rvalid without read", 64'd1, 64'd0);
            else begin
                e_0 = q_0.pop_front();
                chk(d0_rdata == e_0.data[31:0], "R1 d0 read data", 64'(d0_rdata), e_0.data);
                chk(cyc == e_0.due, "R7 d0 return cycle", 64'(cyc), 64'(e_0.due));
            end
        end
        if (rst_n && d1_rvalid) begin
            if (q_1.size() == 0) chk(1'b0, "R7 d1 rvalid without read", 64'd1, 64'd0);
            else begin
                e_1 = q_1.pop_front();
                chk(d1_rdata == e_1.data[31:0], "R1 d1 read data", 64'(d1_rdata), e_1.data);
                chk(cyc == e_1.due, "R7 d1 return cycle", 64'(cyc), 64'(e_1.due));
            end
        end
    end

    task automatic dma_burst(input int p, input int start, input int n, input int step,
                             input bit we, input logic [31:0] wbase);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            a = AW'(start + i * step);
            @(negedge clk);
            if (p == 0) begin d0_valid = 1'b1; d0_addr = a; d0_we = we; d0_wdata = wbase + 32'(i); end
            else        begin d1_valid = 1'b1; d1_addr = a; d1_we = we; d1_wdata = wbase + 32'(i); end
            #1;
            while (!(p == 0 ? d0_ready : d1_ready)) begin
                @(negedge clk);
                #1;
            end
            if (p == 0) g0[i] = cyc; else g1[i] = cyc;
            if (we) model[a] = wbase + 32'(i);
            else if (p == 0) q_0.push_back('{64'(model[a]), cyc + 1});
            else             q_1.push_back('{64'(model[a]), cyc + 1});
        end
        @(negedge clk);
        if (p == 0) d0_valid = 1'b0; else d1_valid = 1'b0;
    endtask

    task automatic cpu_burst(input int start, input int n, input bit we, input logic [63:0] wd);
        for (int i = 0; i < n; i++) begin
            logic [AW-2:0] a;
            int lo;
            a  = (AW-1)'(start + i);
            lo = 2 * int'(a);
            @(negedge clk);
            cpu_valid = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
            #1;
            chk(cpu_ready == 1'b1, "R3 cpu granted at once", 64'(cpu_ready), 64'd1);
            while (!cpu_ready) begin
                @(negedge clk);
                #1;
            end
            gc[i] = cyc;
            if (we) begin
                model[lo] = wd[31:0];
                model[lo + 1] = wd[63:32];
            end else begin
                q_c.push_back('{{model[lo + 1], model[lo]}, cyc + 1});
            end
        end
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic do_reset(input bit rr);
        @(negedge clk);
        rst_n = 1'b0;
        rr_mode = rr;
        repeat (3) @(negedge clk);
        chk(!cpu_rvalid && !d0_rvalid && !d1_rvalid, "R8 rvalid low in reset",
            {61'd0, cpu_rvalid, d0_rvalid, d1_rvalid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_rvalid && !d0_rvalid && !d1_rvalid, "R8 rvalid low after reset",
            {61'd0, cpu_rvalid, d0_rvalid, d1_rvalid}, 64'd0);
    endtask

    initial begin
        do_reset(1'b0);

        // R1: fill through DMA0, read back through DMA1
        dma_burst(0, 0, NWORDS, 1, 1'b1, 32'h5A00_0100);
        dma_burst(1, 0, NWORDS, 1, 1'b0, 32'd0);
        @(negedge clk);
        chk(!d0_rvalid && !d1_rvalid, "R7 no rvalid after writes only", 64'(d1_rvalid), 64'd0);

        // R2: processor pair write, DMA readback of each half, processor readback
        cpu_burst(3, 1, 1'b1, 64'hC0DE_1234_BEEF_5678);
        dma_burst(0, 6, 1, 1, 1'b0, 32'd0);
        dma_burst(1, 7, 1, 1, 1'b0, 32'd0);
        cpu_burst(3, 1, 1'b0, 64'd0);
        chk(model[6] == 32'hBEEF_5678, "R2 low half to even word", 64'(model[6]), 64'hBEEF_5678);

        // R4: processor 128-bit read against two DMA bursts over banks 0-3
        fork
            cpu_burst(0, 2, 1'b0, 64'd0);
            dma_burst(0, 0, 4, 1, 1'b0, 32'd0);
            dma_burst(1, 0, 4, 1, 1'b0, 32'd0);
        join
        chk(gc[1] == gc[0] + 1, "R3 cpu second beat next cycle", 64'(gc[1]), 64'(gc[0] + 1));
        for (int i = 0; i < 4; i++) begin
            chk(g0[i] == gc[0] + 1 + i, "R4 dma0 beat cycle", 64'(g0[i]), 64'(gc[0] + 1 + i));
            chk(g1[i] == gc[0] + 2 + i, "R4 dma1 beat cycle", 64'(g1[i]), 64'(gc[0] + 2 + i));
        end

        // R5: fixed priority, both DMAs stay in bank 0
        fork
            dma_burst(0, 4, 3, 4, 1'b0, 32'd0);
            dma_burst(1, 16, 3, 4, 1'b0, 32'd0);
        join
        for (int i = 0; i < 3; i++) begin
            chk(g0[i] == g0[0] + i, "R5 dma0 uninterrupted", 64'(g0[i]), 64'(g0[0] + i));
            chk(g1[i] == g0[0] + 3 + i, "R5 dma1 waits for dma0", 64'(g1[i]), 64'(g0[0] + 3 + i));
        end

        // R6: round-robin alternation in bank 0
        do_reset(1'b1);
        fork
            dma_burst(0, 4, 3, 4, 1'b0, 32'd0);
            dma_burst(1, 16, 3, 4, 1'b0, 32'd0);
        join
        for (int i = 0; i < 3; i++) begin
            chk(g0[i] == g0[0] + 2 * i, "R6 dma0 alternate slots", 64'(g0[i]), 64'(g0[0] + 2 * i));
            chk(g1[i] == g0[0] + 1 + 2 * i, "R6 dma1 alternate slots", 64'(g1[i]), 64'(g0[0] + 1 + 2 * i));
        end

        // R6: a lone DMA0 grant in bank 3 turns that bank's pointer to DMA1
        dma_burst(0, 3, 1, 1, 1'b0, 32'd0);
        fork
            dma_burst(0, 7, 1, 1, 1'b0, 32'd0);
            dma_burst(1, 11, 1, 1, 1'b0, 32'd0);
        join
        chk(g1[0] < g0[0], "R6 bank3 favours dma1 after dma0 grant", 64'(g1[0]), 64'(g0[0]));

        // R6: untouched bank 2 still favours DMA0
        fork
            dma_burst(0, 2, 1, 1, 1'b0, 32'd0);
            dma_burst(1, 6, 1, 1, 1'b0, 32'd0);
        join
        chk(g0[0] < g1[0], "R6 bank2 still favours dma0", 64'(g0[0]), 64'(g1[0]));

        // R3: processor keeps priority in round-robin mode
        fork
            cpu_burst(0, 1, 1'b0, 64'd0);
            dma_burst(0, 0, 1, 1, 1'b0, 32'd0);
            dma_burst(1, 1, 1, 1, 1'b0, 32'd0);
        join
        chk(g0[0] == gc[0] + 1, "R3 dma0 after cpu in rr mode", 64'(g0[0]), 64'(gc[0] + 1));

        repeat (3) @(negedge clk);
        chk(q_c.size() == 0 && q_0.size() == 0 && q_1.size() == 0, "R7 all reads returned",
            64'(q_c.size() + q_0.size() + q_1.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule